// File: doc/BRIEF.md
# Locking Fixed-Priority Request Multiplexer

This block connects several bus managers to a single subordinate on a valid/ready request bus whose response comes back a fixed number of cycles after each accepted request, with no response handshake. Every cycle a fixed-priority arbiter picks one manager. Its request fields are forwarded to the subordinate, and its ready is driven from the subordinate's ready. Every other manager sees ready low and has to wait.

Each request carries a lock flag. When a locked request is accepted, the grant stays on that manager. Other managers are held off, even those with higher priority. The lock lasts until the same manager has an unlocked request accepted. A manager can use this to make a multi-beat sequence atomic, for example two 32-bit halves of a 64-bit counter.

The index of the manager behind each accepted request is carried through a pipeline that is as deep as the response delay. When the subordinate's read data arrives, it is steered back to that manager, together with a one-cycle response-valid pulse.

Top module: `lockarb_mux`

## Requirements
- R1: While no lock is held, the requesting manager with the lowest index is granted. Manager 0 has the highest priority.
- R2: At most one manager sees ready high in any cycle. That manager's ready equals the subordinate ready, and every other manager sees ready low.
- R3: The subordinate receives the granted manager's valid, lock, write-enable, address and write data. The subordinate valid is low when the granted manager is not requesting.
- R4: After a request with the lock flag set is accepted, only that manager can be granted. This holds even while it is idle and a higher-priority manager requests.
- R5: When the locking manager has a request without the lock flag accepted, the lock is released. Priority arbitration applies again from the next cycle.
- R6: A request with the lock flag set that is not accepted, because the subordinate ready is low, takes no lock.
- R7: With the default response delay of 1, response-valid bit i pulses exactly one cycle after a request from manager i is accepted. In that cycle manager i's read-data slice equals the subordinate read data.
- R8: Synchronous active-high reset clears any held lock and any pending response. After reset no response-valid is high, and priority arbitration is free.
- R9: When no manager requests and no lock is held, every ready is low and the subordinate valid is low.
- R10: The read-data slice of every manager without a response this cycle is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m_vld | input | N_MGR | Request valid per manager |
| m_lock | input | N_MGR | Lock flag per manager request |
| m_wen | input | N_MGR | Write enable per manager request |
| m_adr | input | N_MGR*AW | Addresses, manager i in slice i |
| m_wdt | input | N_MGR*DW | Write data, manager i in slice i |
| m_rdy | output | N_MGR | Request ready per manager |
| m_rvld | output | N_MGR | Response valid per manager |
| m_rdt | output | N_MGR*DW | Read data per manager, zero when no response |
| s_vld | output | 1 | Request valid to subordinate |
| s_lock | output | 1 | Lock flag to subordinate |
| s_wen | output | 1 | Write enable to subordinate |
| s_adr | output | AW | Address to subordinate |
| s_wdt | output | DW | Write data to subordinate |
| s_rdy | input | 1 | Subordinate request ready |
| s_rdt | input | DW | Subordinate read data, valid DLY cycles after acceptance |

## Verification
The hardest situation to bring about is a held lock whose owner has gone idle while a higher-priority manager keeps requesting. The grant must stay parked on the idle owner, and it must not move when the owner's unlocking request is stalled by the subordinate. The vector table walks through that sequence on purpose: a locked transfer from the lowest-priority manager, idle and stalled cycles while the others request, then the release. It also places a locked request under a stalled subordinate, to show that no lock is taken. A directed test asserts reset while a lock and a response are both outstanding.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

  // width of an index that selects one of n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lockarb_pick.sv
module lockarb_pick #(
  parameter int N_MGR = 3,
  parameter int IW    = 2
) (
  input  logic [N_MGR-1:0] req,
  input  logic             lock_on,
  input  logic [IW-1:0]    owner,
  output logic [N_MGR-1:0] gnt,
  output logic [IW-1:0]    sel
);

  always_comb begin
    gnt = '0;
    sel = '0;
    if (lock_on) begin
      gnt[owner] = 1'b1;
      sel        = owner;
    end else begin
      for (int i = N_MGR - 1; i >= 0; i--) begin
        if (req[i]) begin
          gnt    = '0;
          gnt[i] = 1'b1;
          sel    = IW'(i);
        end
      end
    end
  end

endmodule

// File: rtl/lockarb_hold.sv
module lockarb_hold #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic          xfer_lock,
  input  logic [IW-1:0] xfer_idx,
  output logic          lock_on,
  output logic [IW-1:0] owner
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_on <= 1'b0;
      owner   <= '0;
    end else if (xfer) begin
      lock_on <= xfer_lock;
      owner   <= xfer_idx;
    end
  end

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && !xfer_lock) |=> !lock_on);

  assert_lock_take_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer && xfer_lock) |=> (lock_on && owner == $past(xfer_idx)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> !lock_on);

endmodule

// File: rtl/lockarb_resp.sv
module lockarb_resp #(
  parameter int N_MGR = 3,
  parameter int IW    = 2,
  parameter int DW    = 32,
  parameter int DLY   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xfer,
  input  logic [IW-1:0]      xfer_idx,
  input  logic [DW-1:0]      s_rdt,
  output logic [N_MGR-1:0]   m_rvld,
  output logic [N_MGR*DW-1:0] m_rdt
);

  logic          rv;
  logic [IW-1:0] ri;

  generate
    if (DLY == 0) begin : g_comb
      assign rv = xfer;
      assign ri = xfer_idx;
    end else begin : g_pipe
      logic [DLY-1:0] v_sr;
      logic [IW-1:0]  i_sr [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          v_sr <= '0;
        end else begin
          v_sr[0] <= xfer;
          for (int k = 1; k < DLY; k++) v_sr[k] <= v_sr[k-1];
        end
        i_sr[0] <= xfer_idx;
        for (int k = 1; k < DLY; k++) i_sr[k] <= i_sr[k-1];
      end
      assign rv = v_sr[DLY-1];
      assign ri = i_sr[DLY-1];
    end
  endgenerate

  generate
    for (genvar g = 0; g < N_MGR; g++) begin : g_out
      assign m_rvld[g]           = rv && (ri == IW'(g));
      assign m_rdt[g*DW +: DW]   = m_rvld[g] ? s_rdt : '0;
    end
  endgenerate

  assert_resp_single_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_rvld));

endmodule

// File: rtl/lockarb_mux.sv
module lockarb_mux #(
  parameter int N_MGR = 3,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DLY   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_MGR-1:0]    m_vld,
  input  logic [N_MGR-1:0]    m_lock,
  input  logic [N_MGR-1:0]    m_wen,
  input  logic [N_MGR*AW-1:0] m_adr,
  input  logic [N_MGR*DW-1:0] m_wdt,
  output logic [N_MGR-1:0]    m_rdy,
  output logic [N_MGR-1:0]    m_rvld,
  output logic [N_MGR*DW-1:0] m_rdt,
  output logic                s_vld,
  output logic                s_lock,
  output logic                s_wen,
  output logic [AW-1:0]       s_adr,
  output logic [DW-1:0]       s_wdt,
  input  logic                s_rdy,
  input  logic [DW-1:0]       s_rdt
);

  localparam int IW = lockarb_pkg::idx_w(N_MGR);

  logic [N_MGR-1:0] gnt;
  logic [IW-1:0]    sel;
  logic             lock_on;
  logic [IW-1:0]    owner;
  logic             xfer;

  lockarb_pick #(.N_MGR(N_MGR), .IW(IW)) i_pick (
    .req(m_vld), .lock_on(lock_on), .owner(owner), .gnt(gnt), .sel(sel)
  );

  assign s_vld  = |(gnt & m_vld);
  assign s_lock = m_lock[sel];
  assign s_wen  = m_wen[sel];
  assign s_adr  = m_adr[sel*AW +: AW];
  assign s_wdt  = m_wdt[sel*DW +: DW];
  assign m_rdy  = gnt & {N_MGR{s_rdy}};
  assign xfer   = s_vld & s_rdy;

  lockarb_hold #(.IW(IW)) i_hold (
    .clk(clk), .rst(rst), .xfer(xfer), .xfer_lock(s_lock), .xfer_idx(sel),
    .lock_on(lock_on), .owner(owner)
  );

  lockarb_resp #(.N_MGR(N_MGR), .IW(IW), .DW(DW), .DLY(DLY)) i_resp (
    .clk(clk), .rst(rst), .xfer(xfer), .xfer_idx(sel), .s_rdt(s_rdt),
    .m_rvld(m_rvld), .m_rdt(m_rdt)
  );

  assert_single_ready_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_rdy));

  assert_lock_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (s_vld && s_rdy && s_lock) |=> ((m_rdy & ~$past(m_rdy)) == '0));

  assert_top_prio_R1: assert property (@(posedge clk) disable iff (rst)
    (!lock_on && m_vld[0]) |-> (m_rdy[0] == s_rdy));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!lock_on && m_vld == '0) |-> (m_rdy == '0 && !s_vld));

endmodule

// File: tb/test_lockarb_mux.sv
module test_lockarb_mux;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  vld = '0, lck = '0;
  logic [2:0]  wen = 3'b010;
  logic [47:0] adr = {16'h1002, 16'h1001, 16'h1000};
  logic [95:0] wdt = {32'hD000_0002, 32'hD000_0001, 32'hD000_0000};
  logic        srdy = 1'b0;
  logic [31:0] srdt = '0;
  logic [2:0]  m_rdy, m_rvld;
  logic [95:0] m_rdt;
  logic        s_vld, s_lock, s_wen;
  logic [15:0] s_adr;
  logic [31:0] s_wdt;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  lockarb_mux i_lockarb_mux (
    .clk(clk), .rst(rst), .m_vld(vld), .m_lock(lck), .m_wen(wen),
    .m_adr(adr), .m_wdt(wdt), .m_rdy(m_rdy), .m_rvld(m_rvld), .m_rdt(m_rdt),
    .s_vld(s_vld), .s_lock(s_lock), .s_wen(s_wen), .s_adr(s_adr),
    .s_wdt(s_wdt), .s_rdy(srdy), .s_rdt(srdt)
  );

  // row = {vld[2:0], lock[2:0], s_rdy, expected ready[2:0], expected sel (3 = none)}
  localparam logic [11:0] TBL [0:17] = '{
    12'b000_000_1_000_11, // R9 idle
    12'b111_000_1_001_00, // R1 m0 wins
    12'b110_000_1_010_01, // R1 m1 wins
    12'b100_000_1_100_10, // R1 m2 alone
    12'b110_100_1_010_01, // R1 m2 lock request loses
    12'b100_100_0_000_10, // R6 locked request stalled
    12'b011_000_1_001_00, // R6 no lock was taken
    12'b100_100_1_100_10, // R4 m2 locks
    12'b011_000_1_100_10, // R4 owner idle, others held
    12'b111_100_1_100_10, // R4 still locked
    12'b111_000_0_000_10, // R4 unlock stalled
    12'b111_000_1_100_10, // R5 unlock accepted
    12'b011_000_1_001_00, // R5 priority again
    12'b001_001_1_001_00, // R4 m0 locks
    12'b010_000_1_001_00, // R4 m1 held off
    12'b001_000_1_001_00, // R5 m0 releases
    12'b010_000_1_010_01, // R5 m1 granted
    12'b000_000_1_000_11  // R9 idle
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [2:0] prev_x;
    logic [2:0] er;
    logic [1:0] es;
    logic       esv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(m_rvld == 3'b000, "R8", "rvld after reset", 96'(m_rvld), 96'(0));
    chk(m_rdy == 3'b000 && !s_vld, "R9", "idle after reset", 96'(m_rdy), 96'(0));

    prev_x = '0;
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      vld  = TBL[k][11:9];
      lck  = TBL[k][8:6];
      srdy = TBL[k][5];
      srdt = 32'hA000_0000 + 32'(k);
      #1;
      er  = TBL[k][4:2];
      es  = TBL[k][1:0];
      esv = (es == 2'd3) ? 1'b0 : vld[es];
      chk(m_rdy == er, "R1/R2/R4", $sformatf("ready row %0d", k), 96'(m_rdy), 96'(er));
      chk(s_vld == esv, "R3", $sformatf("s_vld row %0d", k), 96'(s_vld), 96'(esv));
      if (es != 2'd3) begin
        chk(s_adr == adr[es*16 +: 16] && s_wdt == wdt[es*32 +: 32] &&
            s_lock == lck[es] && s_wen == wen[es], "R3",
            $sformatf("fields row %0d", k), 96'(s_adr), 96'(adr[es*16 +: 16]));
      end
      chk(m_rvld == prev_x, "R7", $sformatf("rvld row %0d", k), 96'(m_rvld), 96'(prev_x));
      for (int i = 0; i < 3; i++) begin
        chk(m_rdt[i*32 +: 32] == (prev_x[i] ? srdt : 32'h0), "R7/R10",
            $sformatf("rdt mgr %0d row %0d", i, k), 96'(m_rdt[i*32 +: 32]),
            96'(prev_x[i] ? srdt : 32'h0));
      end
      prev_x = er & vld;
    end

    // R8: reset while m1 holds a lock and has a response pending
    @(negedge clk);
    vld = 3'b010; lck = 3'b010; srdy = 1'b1;
    @(negedge clk);
    rst = 1'b1; vld = 3'b001; lck = 3'b000;
    #1;
    chk(m_rdy == 3'b010, "R4", "lock held before reset", 96'(m_rdy), 96'(3'b010));
    chk(m_rvld == 3'b010, "R7", "response before reset", 96'(m_rvld), 96'(3'b010));
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(m_rdy == 3'b001, "R8", "lock cleared by reset", 96'(m_rdy), 96'(3'b001));
    chk(m_rvld == 3'b000, "R8", "no response after reset", 96'(m_rvld), 96'(0));
    @(negedge clk);
    vld = 3'b000;
    #1;
    chk(m_rvld == 3'b001, "R7", "response after reset", 96'(m_rvld), 96'(3'b001));
    chk(m_rdy == 3'b000, "R9", "idle at end", 96'(m_rdy), 96'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule